// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts hardware events for a processor core. It holds one free-running cycle counter and a parameterised number of event counters (four by default), all 32 bits wide. Each event counter carries an 8-bit event code that picks one line of the `events_i` bus. Whenever that line is high during an enabled clock cycle, the counter advances by one. The cycle counter advances on every enabled clock, or once per 64 enabled clocks when the prescale bit is set.

Software reaches the unit through a flat register port. A write is committed at the clock edge on which `reg_wr` is high. A read is combinational from `reg_addr`. Event counters are reached indirectly: software writes a counter index to the select register, and the event-type and counter-data registers then act on that counter. Counter enables and interrupt enables each have a set address and a clear address. Overflow flags are write-one-to-clear. `irq_o` is high while any flag is set and its interrupt is enabled.

Sampling works by loading the two's-complement negative of a period P into a counter. The counter then wraps, and raises its flag, after exactly P counted events.

Top module: `perf_monitor_unit`

## Requirements
- R1: While control bit 0 (global enable) is 0, no counter advances, whatever the event inputs and enables are.
- R2: A control write with bit 1 set zeroes every event counter, and a control write with bit 2 set zeroes the cycle counter and its prescaler. Both bits read back as 0, and neither affects the other group of counters.
- R3: With control bit 3 set, the cycle counter advances once every 64 enabled clocks. After a control write that sets bits 0, 2 and 3 together, the counter is still 0 after 63 more clocks and is 1 after 64. With bit 3 clear, it advances on every enabled clock.
- R4: The control register reads as bits 0, 3, 4 and 5 as written, bits [15:11] as the number of event counters (4), and all other bits as 0. The reset value therefore reads as 0x00002000.
- R5: Writing 1 to bit n of the enable-set or enable-clear address sets or clears the enable of counter n, and a 0 bit leaves it unchanged. The same holds for the interrupt-set and interrupt-clear addresses. Bits 0–3 belong to the event counters and bit 31 to the cycle counter. Both addresses of a pair read back the current enable state, and unimplemented bits read as 0. A counter whose enable is clear does not advance.
- R6: An enabled event counter advances by one on each clock edge at which the `events_i` bit indexed by its event code is high. A code of 32 or above counts nothing.
- R7: The event-type register (code in bits [7:0]) and the event counter-data register act on the counter whose index was last written to the select register. A select write with a value of 4 or more is ignored.
- R8: A counter that advances from 0xFFFFFFFF wraps to 0 and keeps counting, and its overflow flag is set at that same edge. Flag bits 0–3 belong to the event counters and bit 31 to the cycle counter. A counter loaded with 0xFFFFFFFD wraps on its third counted event.
- R9: Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. If a wrap and a clear of the same flag fall on the same edge, the flag stays set.
- R10: `irq_o` is high exactly when some counter has both its overflow flag and its interrupt enable set.
- R11: A counter-data write wins over a count on the same edge: the counter then holds exactly the written value.
- R12: Register offsets: 0 control, 1 enable set, 2 enable clear, 3 interrupt set, 4 interrupt clear, 5 overflow flags, 6 counter select, 7 event type, 8 event counter data, 9 cycle counter data. Any other offset reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, committed at the clock edge |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| events_i | input | NUM_EVT_IN (32) | One-bit event lines, selected by the event codes |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
Every register write, count, wrap and flag change takes effect at the single clock edge on which it is presented. Read data and `irq_o` are combinational, so their values are valid right after that edge. The bench drives inputs on the falling edge and samples outputs one nanosecond after the falling edge that follows a committed write. This places each read after exactly the rising edges that are intended to count. Event tallies are collected at the moment each event pattern is driven, because each pattern is counted at the very next rising edge. Prescaled cycle counts are checked at exactly 63 and 64 clocks after the reset write.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 4;
  localparam int CODE_W  = 8;
  localparam int CYC_BIT = 31;
  localparam int EVT_MAX = 256;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL    = 4'd0,
    A_CEN_SET = 4'd1,
    A_CEN_CLR = 4'd2,
    A_IEN_SET = 4'd3,
    A_IEN_CLR = 4'd4,
    A_OVF     = 4'd5,
    A_SEL     = 4'd6,
    A_EVTYPE  = 4'd7,
    A_EVDATA  = 4'd8,
    A_CYCDATA = 4'd9
  } reg_addr_e;

  // Increment with carry out: bit DATA_W is the wrap indication.
  function automatic logic [DATA_W:0] ctr_step(input logic [DATA_W-1:0] v);
    return {1'b0, v} + {{DATA_W{1'b0}}, 1'b1};
  endfunction

  // Pick one event line by code; codes past the bus read as 0.
  function automatic logic evt_pick(input logic [EVT_MAX-1:0] ev,
                                    input logic [CODE_W-1:0] code);
    return ev[code];
  endfunction

  // Implemented bits of the enable and flag registers.
  function automatic logic [DATA_W-1:0] impl_mask(input int n);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < n; i++) m[i] = 1'b1;
    m[CYC_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter
  import pmu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic              step_i,
  output logic [DATA_W-1:0] value_o,
  output logic              wrap_o
);
  logic [DATA_W:0] nxt;

  always_comb nxt = ctr_step(value_o);

  // Wrap is only reported for a real count, never for a load or a clear.
  assign wrap_o = step_i && !clear_i && !load_i && nxt[DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       value_o <= '0;
    else if (clear_i) value_o <= '0;
    else if (load_i)  value_o <= load_val_i;
    else if (step_i)  value_o <= nxt[DATA_W-1:0];
  end
endmodule

// File: rtl/pmu_prescaler.sv
module pmu_prescaler #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  input  logic div_en_i,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  assign tick_o = run_i && (!div_en_i || pre_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (clear_i) pre_q <= '0;
    else if (run_i)   pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/perf_monitor_unit.sv
module perf_monitor_unit
  import pmu_pkg::*;
#(
  parameter int NUM_CTR    = 4,
  parameter int NUM_EVT_IN = 32,
  parameter int PRESCALE   = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic [NUM_EVT_IN-1:0] events_i,
  output logic                  irq_o
);
  localparam int SEL_W = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;
  localparam logic [DATA_W-1:0] IMPL = impl_mask(NUM_CTR);

  // Write decode
  logic wr_ctrl, wr_cen_set, wr_cen_clr, wr_ien_set, wr_ien_clr;
  logic wr_ovf, wr_sel, wr_evtype, wr_evdata, wr_cycdata;
  assign wr_ctrl    = reg_wr && reg_addr == A_CTRL;
  assign wr_cen_set = reg_wr && reg_addr == A_CEN_SET;
  assign wr_cen_clr = reg_wr && reg_addr == A_CEN_CLR;
  assign wr_ien_set = reg_wr && reg_addr == A_IEN_SET;
  assign wr_ien_clr = reg_wr && reg_addr == A_IEN_CLR;
  assign wr_ovf     = reg_wr && reg_addr == A_OVF;
  assign wr_sel     = reg_wr && reg_addr == A_SEL;
  assign wr_evtype  = reg_wr && reg_addr == A_EVTYPE;
  assign wr_evdata  = reg_wr && reg_addr == A_EVDATA;
  assign wr_cycdata = reg_wr && reg_addr == A_CYCDATA;

  // Named internal events
  logic ev_clear, cyc_clear, cnt_write;
  logic [DATA_W-1:0] ovf_clr;
  assign ev_clear  = wr_ctrl && reg_wdata[1];
  assign cyc_clear = wr_ctrl && reg_wdata[2];
  assign cnt_write = ev_clear || cyc_clear || wr_evdata || wr_cycdata;
  assign ovf_clr   = wr_ovf ? reg_wdata : '0;

  // Control, enable and select state
  logic en_q, div_q, exp_q, dbg_q;
  logic [DATA_W-1:0] cnten_q, inten_q, ovf_q;
  logic [SEL_W-1:0]  sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {en_q, div_q, exp_q, dbg_q} <= '0;
      cnten_q <= '0;
      inten_q <= '0;
      sel_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= reg_wdata[0];
        div_q <= reg_wdata[3];
        exp_q <= reg_wdata[4];
        dbg_q <= reg_wdata[5];
      end
      if (wr_cen_set)      cnten_q <= (cnten_q | reg_wdata) & IMPL;
      else if (wr_cen_clr) cnten_q <= cnten_q & ~reg_wdata;
      if (wr_ien_set)      inten_q <= (inten_q | reg_wdata) & IMPL;
      else if (wr_ien_clr) inten_q <= inten_q & ~reg_wdata;
      if (wr_sel && reg_wdata < DATA_W'(NUM_CTR)) sel_q <= reg_wdata[SEL_W-1:0];
    end
  end

  // Event counters
  logic [EVT_MAX-1:0] ev_ext;
  logic [CODE_W-1:0]  code_q [NUM_CTR];
  logic [DATA_W-1:0]  ev_val [NUM_CTR];
  logic [NUM_CTR-1:0] ev_wrap;
  logic [NUM_CTR*DATA_W-1:0] ev_flat;

  assign ev_ext = EVT_MAX'(events_i);

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic hit, sel_me;
    assign sel_me = (sel_q == SEL_W'(i));
    assign hit    = en_q && cnten_q[i] && evt_pick(ev_ext, code_q[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  code_q[i] <= '0;
      else if (wr_evtype && sel_me) code_q[i] <= reg_wdata[CODE_W-1:0];
    end

    pmu_counter u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (ev_clear),
      .load_i     (wr_evdata && sel_me),
      .load_val_i (reg_wdata),
      .step_i     (hit),
      .value_o    (ev_val[i]),
      .wrap_o     (ev_wrap[i])
    );
    assign ev_flat[i*DATA_W +: DATA_W] = ev_val[i];
  end

  // Cycle counter with prescaler
  logic cyc_tick, cyc_wrap;
  logic [DATA_W-1:0] cyc_val;

  pmu_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (cyc_clear),
    .run_i    (en_q && cnten_q[CYC_BIT]),
    .div_en_i (div_q),
    .tick_o   (cyc_tick)
  );

  pmu_counter u_cyc (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (cyc_clear),
    .load_i     (wr_cycdata),
    .load_val_i (reg_wdata),
    .step_i     (cyc_tick),
    .value_o    (cyc_val),
    .wrap_o     (cyc_wrap)
  );

  // Overflow flags: a wrap beats a clear on the same edge
  logic [DATA_W-1:0] wrap_vec;
  always_comb begin
    wrap_vec = '0;
    for (int i = 0; i < NUM_CTR; i++) wrap_vec[i] = ev_wrap[i];
    wrap_vec[CYC_BIT] = cyc_wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= '0;
    else        ovf_q <= ((ovf_q & ~ovf_clr) | wrap_vec) & IMPL;
  end

  assign irq_o = |(ovf_q & inten_q);

  // Read mux
  always_comb begin
    unique case (reg_addr)
      A_CTRL:               reg_rdata = {16'b0, 5'(NUM_CTR), 5'b0, dbg_q, exp_q,
                                         div_q, 2'b00, en_q};
      A_CEN_SET, A_CEN_CLR: reg_rdata = cnten_q;
      A_IEN_SET, A_IEN_CLR: reg_rdata = inten_q;
      A_OVF:                reg_rdata = ovf_q;
      A_SEL:                reg_rdata = DATA_W'(sel_q);
      A_EVTYPE:             reg_rdata = DATA_W'(code_q[sel_q]);
      A_EVDATA:             reg_rdata = ev_val[sel_q];
      A_CYCDATA:            reg_rdata = cyc_val;
      default:              reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker
  import pmu_pkg::*;
#(
  parameter int NUM_CTR = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      gen_en,
  input logic                      cnt_write,
  input logic [NUM_CTR*DATA_W-1:0] ev_flat,
  input logic [DATA_W-1:0]         cyc_val,
  input logic                      ev_clear,
  input logic                      cyc_clear,
  input logic [DATA_W-1:0]         wrap_vec,
  input logic [DATA_W-1:0]         ovf_clr,
  input logic [DATA_W-1:0]         ovf_q,
  input logic [DATA_W-1:0]         inten_q,
  input logic                      irq_o
);
  localparam logic [DATA_W-1:0] IMPL = impl_mask(NUM_CTR);

  p_halt_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_en && !cnt_write) |=> ($stable(ev_flat) && $stable(cyc_val)));

  p_evreset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clear |=> (ev_flat == '0));

  p_cycreset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_clear |=> (cyc_val == '0));

  p_ovf_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_vec != '0) |=> ((ovf_q & $past(wrap_vec)) == $past(wrap_vec)));

  p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovf_clr & IMPL) != '0 && wrap_vec == '0) |=> ((ovf_q & $past(ovf_clr)) == '0));

  p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (ovf_q != $past(ovf_q) || inten_q != $past(inten_q)));
endmodule

bind perf_monitor_unit pmu_checker #(.NUM_CTR(NUM_CTR)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .gen_en    (en_q),
  .cnt_write (cnt_write),
  .ev_flat   (ev_flat),
  .cyc_val   (cyc_val),
  .ev_clear  (ev_clear),
  .cyc_clear (cyc_clear),
  .wrap_vec  (wrap_vec),
  .ovf_clr   (ovf_clr),
  .ovf_q     (ovf_q),
  .inten_q   (inten_q),
  .irq_o     (irq_o)
);

// File: tb/perf_monitor_unit_tb_top.sv
`timescale 1ns/100ps
module perf_monitor_unit_tb_top;
  localparam logic [3:0] A_CTRL = 0, A_CEN_SET = 1, A_CEN_CLR = 2, A_IEN_SET = 3,
                         A_IEN_CLR = 4, A_OVF = 5, A_SEL = 6, A_EVTYPE = 7,
                         A_EVDATA = 8, A_CYCDATA = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] events = '0;
  logic        irq_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  perf_monitor_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .events_i(events), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Hold event line 0 high for exactly n counting edges.
  task automatic pulse0(input int n);
    repeat (n) begin @(negedge clk); events = 32'h1; end
    @(negedge clk); events = '0;
  endtask

  function automatic logic [31:0] ctrl_view(input logic [31:0] w);
    return 32'h0000_2000 | (w & 32'h0000_0039);
  endfunction

  function automatic logic [31:0] neg_period(input int p);
    return 32'(-p);
  endfunction

  initial begin
    logic [7:0]  code [4];
    int          tally [4];
    logic [31:0] v;
    void'($urandom(32'd20240611));
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // Reset state
    rd_chk("R4 reset ctrl", A_CTRL, 32'h0000_2000);
    rd_chk("R5 reset enables", A_CEN_SET, 32'h0);
    rd_chk("R8 reset flags", A_OVF, 32'h0);
    chk("R10 reset irq", {31'b0, irq_o}, 32'h0);
    rd_chk("R12 unused offset", 4'd12, 32'h0);

    // Control readback
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd_chk("R4 ctrl writable bits", A_CTRL, ctrl_view(32'hFFFF_FFFF));
    wr(A_CTRL, 32'h0);

    // Enable set/clear
    wr(A_CEN_SET, 32'h8000_00FF);
    rd_chk("R5 enable set", A_CEN_SET, 32'h8000_000F);
    wr(A_CEN_CLR, 32'h8000_0005);
    rd_chk("R5 enable clear", A_CEN_CLR, 32'h0000_000A);
    wr(A_CEN_CLR, 32'h0);
    rd_chk("R5 zero bits keep", A_CEN_SET, 32'h0000_000A);
    wr(A_IEN_SET, 32'h8000_0001);
    rd_chk("R5 irq enable set", A_IEN_SET, 32'h8000_0001);
    wr(A_IEN_CLR, 32'hFFFF_FFFF);
    rd_chk("R5 irq enable clear", A_IEN_CLR, 32'h0);

    // Indirect select
    wr(A_SEL, 2); wr(A_EVTYPE, 32'h08);
    wr(A_SEL, 7);
    rd_chk("R7 bad select ignored", A_SEL, 32'd2);
    rd_chk("R7 selected code", A_EVTYPE, 32'h08);
    wr(A_SEL, 1);
    rd_chk("R7 other counter code", A_EVTYPE, 32'h0);

    // Global enable off: nothing counts
    wr(A_SEL, 0); wr(A_EVTYPE, 32'h03);
    wr(A_CEN_SET, 32'h0000_000F);
    @(negedge clk); events = '1;
    idle(10);
    events = '0;
    rd_chk("R1 halted counter", A_EVDATA, 32'h0);

    // Random event patterns, two rounds
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < 4; i++) begin
        code[i] = (i == 3) ? 8'(32 + $urandom_range(0, 200)) : 8'($urandom_range(0, 31));
        if (r == 1 && i == 0) code[i] = 8'h11;
        tally[i] = 0;
        wr(A_SEL, i); wr(A_EVTYPE, {24'b0, code[i]});
      end
      wr(A_CTRL, 32'h3);
      for (int k = 0; k < 300; k++) begin
        @(negedge clk);
        events = (r == 1) ? ($urandom() | 32'h0002_0000) : $urandom();
        for (int i = 0; i < 4; i++)
          if (code[i] < 32 && events[code[i][4:0]]) tally[i]++;
      end
      @(negedge clk); events = '0;
      wr(A_CTRL, 32'h0);
      for (int i = 0; i < 4; i++) begin
        wr(A_SEL, i);
        rd_chk($sformatf("R6 round %0d counter %0d", r, i), A_EVDATA, 32'(tally[i]));
      end
    end

    // Sampling: load negative period, wrap after 3 events
    for (int i = 0; i < 4; i++) begin wr(A_SEL, i); wr(A_EVTYPE, 32'h05); end
    wr(A_SEL, 0); wr(A_EVTYPE, 32'h00);
    wr(A_EVDATA, neg_period(3));
    wr(A_OVF, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'h1);
    pulse0(2);
    rd_chk("R8 before wrap", A_EVDATA, 32'hFFFF_FFFF);
    rd_chk("R8 no flag yet", A_OVF, 32'h0);
    pulse0(1);
    rd_chk("R8 wrapped to zero", A_EVDATA, 32'h0);
    rd_chk("R8 flag bit0", A_OVF, 32'h1);
    pulse0(2);
    rd_chk("R8 counts on", A_EVDATA, 32'h2);

    // Interrupt
    #1 chk("R10 flag without enable", {31'b0, irq_o}, 32'h0);
    wr(A_IEN_SET, 32'h8000_0001);
    #1 chk("R10 flag and enable", {31'b0, irq_o}, 32'h1);
    wr(A_OVF, 32'h0);
    rd_chk("R9 zero write keeps", A_OVF, 32'h1);
    wr(A_OVF, 32'h1);
    rd_chk("R9 flag cleared", A_OVF, 32'h0);
    chk("R10 irq drops", {31'b0, irq_o}, 32'h0);

    // Wrap beats clear on the same edge
    wr(A_SEL, 1); wr(A_EVTYPE, 32'h00); wr(A_EVDATA, 32'hFFFF_FFFF);
    @(negedge clk);
    events = 32'h1; reg_wr = 1'b1; reg_addr = A_OVF; reg_wdata = 32'h2;
    @(negedge clk);
    reg_wr = 1'b0; events = '0;
    rd_chk("R9 set wins over clear", A_OVF, 32'h2);
    wr(A_OVF, 32'h2);

    // Data write beats count
    wr(A_SEL, 0);
    @(negedge clk); events = 32'h1;
    wr(A_EVDATA, 32'd100);
    rd_chk("R11 load wins", A_EVDATA, 32'd100);
    events = '0;

    // Counter resets
    wr(A_CTRL, 32'h3);
    rd_chk("R2 event reset", A_EVDATA, 32'h0);
    rd_chk("R2 reset bits read 0", A_CTRL, 32'h0000_2001);
    wr(A_EVDATA, 32'd55);
    wr(A_CEN_SET, 32'h8000_0000);
    idle(4);
    wr(A_CTRL, 32'h5);
    rd_chk("R2 cycle reset", A_CYCDATA, 32'h0);
    rd_chk("R2 event kept", A_EVDATA, 32'd55);

    // Cycle counter rate and prescale
    idle(10);
    rd_chk("R3 every clock", A_CYCDATA, 32'd10);
    wr(A_CTRL, 32'hD);
    rd_chk("R4 ctrl prescale bit", A_CTRL, 32'h0000_2009);
    idle(63);
    rd_chk("R3 63 clocks", A_CYCDATA, 32'd0);
    idle(1);
    rd_chk("R3 64 clocks", A_CYCDATA, 32'd1);

    // Cycle counter wrap flag
    wr(A_CTRL, 32'h1);
    wr(A_OVF, 32'hFFFF_FFFF);
    wr(A_CYCDATA, 32'hFFFF_FFFF);
    idle(1);
    rd_chk("R8 cycle wrapped", A_CYCDATA, 32'h0);
    rd_chk("R8 flag bit31", A_OVF, 32'h8000_0000);
    #1 chk("R10 cycle irq", {31'b0, irq_o}, 32'h1);

    // Cycle enable cleared: stable
    wr(A_CEN_CLR, 32'h8000_0000);
    reg_addr = A_CYCDATA; #1 v = reg_rdata;
    idle(5);
    rd_chk("R5 disabled cycle counter", A_CYCDATA, v);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog timeout actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule